// File: doc/BRIEF.md
# Bus Cycle Strobe Generator

This block turns a processor's internal bus-cycle request into the external strobes of a shared 16-bit multiplexed address/data bus. When a request arrives while the bus is granted to this processor, the block captures the cycle kind and address and walks through four phases: address, data, wait and end. In the address phase it raises an active-high address latch strobe; external latches take the address on its falling edge. Through the data and wait phases it holds an active-low data strobe together with the single active-low read or write strobe that matches the cycle kind (memory read, memory write, I/O read, I/O write).

An output write to address 0x1000 is treated as an interrupt acknowledge and also drives an active-low acknowledge strobe. A combined ready signal, built from a page-change ready input and an external override, holds the cycle in the wait phase for as many clocks as ready stays low. Output enables are produced instead of driving tri-state pins directly: the address and data strobes float whenever the bus is not granted, and the address and read/write strobes float from the external strobe-enable pin only when the matching control-register enable bit allows it.

Top module: `bus_strobe_gen`

## Requirements
- R1: After reset the block is idle: address strobe low, data strobe, the four read/write strobes and the acknowledge strobe all high.
- R2: A cycle starts only when the request is high and the bus is granted while idle; the address strobe is then high for exactly one clock and all other strobes stay inactive in that clock.
- R3: The cycle kind is encoded 2'b00 memory read, 2'b01 memory write, 2'b10 I/O read, 2'b11 I/O write; during the data and wait phases the data strobe is low and only the matching read/write strobe is low.
- R4: The data phase lasts one clock and always moves to the wait phase; the wait phase repeats while combined ready is low and leaves on the first clock edge at which it is high.
- R5: In the end phase and the following idle clock every strobe is at its inactive level; a new address phase can start no earlier than the clock after that idle clock.
- R6: Combined ready is high only when the page-change ready input is high and the external override input is low.
- R7: The acknowledge strobe is low during the data and wait phases of an I/O write (kind 2'b11) to address 0x1000 and high in every other case.
- R8: The address and data strobe output enables equal the grant input.
- R9: The address output enable is low exactly when the strobe-enable pin is high and the address float bit is set; the read/write strobe output enable is low exactly when the pin is high and the strobe float bit is set.
- R10: The captured address is presented unchanged from the address phase to the end of the cycle, and requests arriving during a cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus cycle request |
| kind_i | input | 2 | Cycle kind (see R3) |
| addr_i | input | 16 | Cycle address |
| grant_i | input | 1 | Bus granted to this processor |
| strb_en_ni | input | 1 | Active-low strobe enable pin |
| float_addr_en_i | input | 1 | Control bit allowing the pin to float the address |
| float_strb_en_i | input | 1 | Control bit allowing the pin to float read/write strobes |
| page_rdy_i | input | 1 | Page-change ready, low inserts a wait |
| ext_rdy_ovr_i | input | 1 | External override, high forces not ready |
| addr_o | output | 16 | Captured address |
| addr_oe_o | output | 1 | Address output enable |
| astb_o | output | 1 | Address latch strobe, active high |
| astb_oe_o | output | 1 | Address strobe output enable |
| dstb_no | output | 1 | Data strobe, active low |
| dstb_oe_o | output | 1 | Data strobe output enable |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| io_rd_no | output | 1 | I/O read strobe, active low |
| io_wr_no | output | 1 | I/O write strobe, active low |
| rw_oe_o | output | 1 | Read/write strobe output enable |
| inta_no | output | 1 | Interrupt acknowledge strobe, active low |
| rdy_o | output | 1 | Combined ready |

## Verification
The main sequence is swept over all four cycle kinds, over addresses on and next to 0x1000 and at zero, and over zero, one and two wait clocks inserted either by the page-change input or by the override; this separates the strobe decode per kind, the acknowledge decode from its near misses, and the wait counting from the ready source. Requests are held high through each cycle to show they are ignored, and a request without grant shows no cycle starts. The enable logic is swept over all eight combinations of pin and float bits and the ready logic over all four input pairs.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_WAIT = 3'd3,
    ST_END  = 3'd4
  } phase_e;

  localparam int unsigned NUM_KINDS = 4;
  localparam logic [1:0] KIND_MEM_RD = 2'b00;
  localparam logic [1:0] KIND_MEM_WR = 2'b01;
  localparam logic [1:0] KIND_IO_RD  = 2'b10;
  localparam logic [1:0] KIND_IO_WR  = 2'b11;
endpackage

// File: rtl/bus_strobe_fsm.sv
module bus_strobe_fsm
  import bus_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              grant_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rdy_i,
  output phase_e            phase_o,
  output logic [1:0]        kind_o,
  output logic [ADDR_W-1:0] addr_o
);
  phase_e phase_q, phase_d;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              start;

  assign start = (phase_q == ST_IDLE) && req_i && grant_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      ST_IDLE: if (start) phase_d = ST_ADDR;
      ST_ADDR: phase_d = ST_DATA;
      ST_DATA: phase_d = ST_WAIT;
      ST_WAIT: if (rdy_i) phase_d = ST_END;
      ST_END:  phase_d = ST_IDLE;
      default: phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_IDLE;
      kind_q  <= '0;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (start) begin
        kind_q <= kind_i;
        addr_q <= addr_i;
      end
    end
  end

  assign phase_o = phase_q;
  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/bus_strobe_decode.sv
module bus_strobe_decode
  import bus_strobe_pkg::*;
#(
  parameter int unsigned  ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ACK_ADDR = 16'h1000
) (
  input  phase_e            phase_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              astb_o,
  output logic              dstb_no,
  output logic [NUM_KINDS-1:0] rw_no,
  output logic              inta_no
);
  logic data_act;

  assign data_act = (phase_i == ST_DATA) || (phase_i == ST_WAIT);
  assign astb_o   = (phase_i == ST_ADDR);
  assign dstb_no  = !data_act;

  for (genvar g = 0; g < NUM_KINDS; g++) begin : g_rw
    assign rw_no[g] = !(data_act && (kind_i == 2'(g)));
  end

  assign inta_no = !(data_act && (kind_i == KIND_IO_WR) && (addr_i == ACK_ADDR));
endmodule

// File: rtl/bus_strobe_drive.sv
module bus_strobe_drive (
  input  logic grant_i,
  input  logic strb_en_ni,
  input  logic float_addr_en_i,
  input  logic float_strb_en_i,
  input  logic page_rdy_i,
  input  logic ext_rdy_ovr_i,
  output logic astb_oe_o,
  output logic dstb_oe_o,
  output logic addr_oe_o,
  output logic rw_oe_o,
  output logic rdy_o
);
  assign astb_oe_o = grant_i;
  assign dstb_oe_o = grant_i;
  // pin floats outputs only where the control bit permits
  assign addr_oe_o = !(strb_en_ni && float_addr_en_i);
  assign rw_oe_o   = !(strb_en_ni && float_strb_en_i);
  assign rdy_o     = page_rdy_i && !ext_rdy_ovr_i;
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] ACK_ADDR = 16'h1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              grant_i,
  input  logic              strb_en_ni,
  input  logic              float_addr_en_i,
  input  logic              float_strb_en_i,
  input  logic              page_rdy_i,
  input  logic              ext_rdy_ovr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic              astb_o,
  output logic              astb_oe_o,
  output logic              dstb_no,
  output logic              dstb_oe_o,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic              rw_oe_o,
  output logic              inta_no,
  output logic              rdy_o
);
  phase_e            phase;
  logic [1:0]        kind_q;
  logic [NUM_KINDS-1:0] rw_n;
  logic              rdy;

  bus_strobe_drive u_drive (
    .grant_i         (grant_i),
    .strb_en_ni      (strb_en_ni),
    .float_addr_en_i (float_addr_en_i),
    .float_strb_en_i (float_strb_en_i),
    .page_rdy_i      (page_rdy_i),
    .ext_rdy_ovr_i   (ext_rdy_ovr_i),
    .astb_oe_o       (astb_oe_o),
    .dstb_oe_o       (dstb_oe_o),
    .addr_oe_o       (addr_oe_o),
    .rw_oe_o         (rw_oe_o),
    .rdy_o           (rdy)
  );

  bus_strobe_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .grant_i (grant_i),
    .kind_i  (kind_i),
    .addr_i  (addr_i),
    .rdy_i   (rdy),
    .phase_o (phase),
    .kind_o  (kind_q),
    .addr_o  (addr_o)
  );

  bus_strobe_decode #(.ADDR_W(ADDR_W), .ACK_ADDR(ACK_ADDR)) u_dec (
    .phase_i (phase),
    .kind_i  (kind_q),
    .addr_i  (addr_o),
    .astb_o  (astb_o),
    .dstb_no (dstb_no),
    .rw_no   (rw_n),
    .inta_no (inta_no)
  );

  assign mem_rd_no = rw_n[KIND_MEM_RD];
  assign mem_wr_no = rw_n[KIND_MEM_WR];
  assign io_rd_no  = rw_n[KIND_IO_RD];
  assign io_wr_no  = rw_n[KIND_IO_WR];
  assign rdy_o     = rdy;
endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk
  import bus_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input phase_e            phase,
  input logic              astb_o,
  input logic              dstb_no,
  input logic              mem_rd_no,
  input logic              mem_wr_no,
  input logic              io_rd_no,
  input logic              io_wr_no,
  input logic              inta_no,
  input logic              rdy_o,
  input logic              page_rdy_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic [3:0] rw_act;
  assign rw_act = ~{io_wr_no, io_rd_no, mem_wr_no, mem_rd_no};

  // R3
  rw_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dstb_no |-> $countones(rw_act) == 1);
  // R3
  rw_needs_dstb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dstb_no |-> rw_act == 4'b0);
  // R2
  astb_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    astb_o |=> (!astb_o && !dstb_no));
  // R5
  gap_after_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dstb_no) |=> !astb_o);
  // R4
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == ST_WAIT && !rdy_o) |=> (phase == ST_WAIT && !dstb_no));
  // R7
  ack_is_io_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_no |-> !io_wr_no);
  // R6
  rdy_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> page_rdy_i);
  // R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dstb_no |-> $stable(addr_o));
endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase      (phase),
  .astb_o     (astb_o),
  .dstb_no    (dstb_no),
  .mem_rd_no  (mem_rd_no),
  .mem_wr_no  (mem_wr_no),
  .io_rd_no   (io_rd_no),
  .io_wr_no   (io_wr_no),
  .inta_no    (inta_no),
  .rdy_o      (rdy_o),
  .page_rdy_i (page_rdy_i),
  .addr_o     (addr_o)
);

// File: tb/bus_strobe_gen_tb_top.sv
module bus_strobe_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic [15:0] addr = 16'h0;
  logic        grant = 1'b0;
  logic        strb_en_n = 1'b0;
  logic        fl_addr = 1'b0;
  logic        fl_strb = 1'b0;
  logic        page_rdy = 1'b1;
  logic        ovr = 1'b0;
  logic [15:0] addr_q;
  logic        addr_oe, astb, astb_oe, dstb_n, dstb_oe;
  logic        mrd_n, mwr_n, iord_n, iowr_n, rw_oe, inta_n, rdy;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_strobe_gen dut_i (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .kind_i (kind), .addr_i (addr),
    .grant_i (grant), .strb_en_ni (strb_en_n), .float_addr_en_i (fl_addr),
    .float_strb_en_i (fl_strb), .page_rdy_i (page_rdy), .ext_rdy_ovr_i (ovr),
    .addr_o (addr_q), .addr_oe_o (addr_oe), .astb_o (astb), .astb_oe_o (astb_oe),
    .dstb_no (dstb_n), .dstb_oe_o (dstb_oe), .mem_rd_no (mrd_n), .mem_wr_no (mwr_n),
    .io_rd_no (iord_n), .io_wr_no (iowr_n), .rw_oe_o (rw_oe), .inta_no (inta_n),
    .rdy_o (rdy)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  // packs strobes: {astb, dstb_n, io_wr_n, io_rd_n, mem_wr_n, mem_rd_n, inta_n}
  function automatic logic [6:0] strobes();
    return {astb, dstb_n, iowr_n, iord_n, mwr_n, mrd_n, inta_n};
  endfunction

  localparam logic [6:0] IDLE_PAT = 7'b0_1_1111_1;

  function automatic logic [6:0] data_pat(input logic [1:0] k, input logic [15:0] a);
    logic [3:0] rw;
    logic       ack;
    rw  = ~(4'b0001 << k);
    ack = !((k == 2'b11) && (a == 16'h1000));
    return {1'b0, 1'b0, rw, ack};
  endfunction

  task automatic set_rdy(input bit use_ovr, input bit ready);
    if (use_ovr) begin page_rdy = 1'b1; ovr = !ready; end
    else         begin page_rdy = ready; ovr = 1'b0; end
  endtask

  task automatic run_cycle(input logic [1:0] k, input logic [15:0] a, input int nwait, input bit use_ovr);
    @(negedge clk);
    req = 1'b1; kind = k; addr = a; grant = 1'b1; set_rdy(use_ovr, 1'b1);
    @(negedge clk);  // address phase
    chk("R2", {25'b0, strobes()}, {25'b0, 7'b1_1_1111_1});
    chk("R10", {16'b0, addr_q}, {16'b0, a});
    kind = ~k; addr = ~a;  // request stays high: must be ignored
    if (nwait > 0) set_rdy(use_ovr, 1'b0);
    @(negedge clk);  // data phase
    chk("R3", {25'b0, strobes()}, {25'b0, data_pat(k, a)});
    chk("R7", {31'b0, inta_n}, {31'b0, data_pat(k, a)[0]});
    @(negedge clk);  // first wait clock
    chk("R4", {25'b0, strobes()}, {25'b0, data_pat(k, a)});
    for (int i = 0; i < nwait; i++) begin
      @(negedge clk);
      chk("R4", {25'b0, strobes()}, {25'b0, data_pat(k, a)});
    end
    set_rdy(use_ovr, 1'b1);
    @(negedge clk);  // end phase
    chk("R5", {25'b0, strobes()}, {25'b0, IDLE_PAT});
    chk("R10", {16'b0, addr_q}, {16'b0, a});
    @(negedge clk);  // idle, request still high sampled next edge
    chk("R5", {25'b0, strobes()}, {25'b0, IDLE_PAT});
    req = 1'b0;
    @(negedge clk);
    chk("R10", {25'b0, strobes()}, {25'b0, IDLE_PAT});
  endtask

  initial begin
    logic [15:0] alist [4];
    alist[0] = 16'h1000; alist[1] = 16'h1001; alist[2] = 16'h0FFF; alist[3] = 16'h0000;
    #35;
    chk("R1", {25'b0, strobes()}, {25'b0, IDLE_PAT});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {25'b0, strobes()}, {25'b0, IDLE_PAT});

    // no grant: no cycle, strobe drivers off
    req = 1'b1; grant = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R2", {25'b0, strobes()}, {25'b0, IDLE_PAT});
      chk("R8", {30'b0, astb_oe, dstb_oe}, 32'd0);
    end
    req = 1'b0; grant = 1'b1;
    @(negedge clk);
    chk("R8", {30'b0, astb_oe, dstb_oe}, 32'd3);

    for (int k = 0; k < 4; k++)
      for (int ai = 0; ai < 4; ai++)
        for (int w = 0; w < 3; w++)
          for (int o = 0; o < 2; o++)
            run_cycle(2'(k), alist[ai], w, o[0]);

    for (int v = 0; v < 8; v++) begin
      {strb_en_n, fl_addr, fl_strb} = 3'(v);
      #1;
      chk("R9", {30'b0, addr_oe, rw_oe},
          {30'b0, !(v[2] && v[1]), !(v[2] && v[0])});
    end
    for (int v = 0; v < 4; v++) begin
      {page_rdy, ovr} = 2'(v);
      #1;
      chk("R6", {31'b0, rdy}, {31'b0, v[1] && !v[0]});
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule